// File: doc/BRIEF.md
# Ternary Match Array with Priority Encoder

This block is a behavioural lookup array of `WORDS` entries, each `BITS` positions wide, in which every position holds a ternary value: zero, one or don't-care. Each position is kept as two storage elements. A search compares a ternary key against all entries at once. Each entry has a match flag. The flag is set to 1 in a precharge cycle, and in the following evaluate cycle any entry with a mismatching position clears it. A priority encoder turns the flags into a hit indication, the index of the lowest-numbered matching entry, and a flag that is high when more than one entry matched.

A write programs one entry in two cycles. The first cycle programs the "one" element of every position and the second cycle programs the "zero" element, so the final content does not depend on what the entry held before. All match flags are held at 0 while a write runs. A search that arrives together with a write, or during its second cycle, is held and then launched as soon as the write ends. A write that arrives while the array is busy is dropped, and so is a search that arrives while another search is running.

Top module: `tcam_array`

## Requirements
- R1: Position i of a stored word or key uses bits [2i+1:2i]. The codes are 2'b00 don't-care, 2'b01 zero, 2'b10 one and 2'b11 reserved. A position matches when the key code is don't-care, or the stored code is don't-care, or both codes are equal and not reserved.
- R2: An entry matches only when all of its positions match. A single mismatching position clears the entry's flag.
- R3: On a result, `addr_o` is the lowest-numbered matching entry. When nothing matches, `hit_o` is 0, `addr_o` is 0 and `multi_o` is 0.
- R4: On a result, `multi_o` is 1 exactly when two or more entries matched.
- R5: Take an idle array that samples `srch_i` at clock edge k. The precharge cycle follows edge k and the evaluate cycle follows edge k+1. `valid_o` is 1 for the single cycle after edge k+2, and `hit_o`, `addr_o` and `multi_o` are valid in that cycle.
- R6: In the evaluate cycle every match flag is 1. While a write is in progress every match flag is 0.
- R7: A write sampled at edge k programs the "one" elements at edge k and the "zero" elements at edge k+1. After that, the entry holds exactly the written codes, whatever it held before.
- R8: A search sampled with a write, or in the write's second cycle, is held. It enters precharge after the write's second edge and sees the newly written content.
- R9: A write request sampled while a write or a search is in progress is ignored and leaves the stored content unchanged.
- R10: A search request sampled during precharge or evaluate is ignored and produces no result.
- R11: After reset every entry holds don't-care in all positions and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| wr_addr_i | input | AW | Entry to program |
| wr_data_i | input | 2*BITS | Ternary codes to store |
| srch_i | input | 1 | Search request |
| srch_key_i | input | 2*BITS | Ternary search key |
| valid_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | At least one entry matched |
| addr_o | output | AW | Lowest matching entry |
| multi_o | output | 1 | Two or more entries matched |

## Verification
Some relations are checked on every cycle: the precharge-then-evaluate ordering, the flags being all ones in the evaluate cycle and all zeros during a write, and the result being consistent with the final flag vector (hit, lowest index, multiple-match count). Other behaviour can only be shown by the bench's scenarios, because it depends on what was stored: the ternary comparison rules, the two-step overwrite of arbitrary old content, stalled searches seeing freshly written data, and dropped requests leaving the content and the result stream unchanged. The bench compares against its own model of the stored codes, and it also checks the exact cycle in which each result appears.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WRB  = 2'd1,
    ST_PRE  = 2'd2,
    ST_EVAL = 2'd3
  } ctl_state_e;

  localparam logic [1:0] TC_DC   = 2'b00;
  localparam logic [1:0] TC_ZERO = 2'b01;
  localparam logic [1:0] TC_ONE  = 2'b10;
  localparam logic [1:0] TC_RSV  = 2'b11;
endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic srch_req_i,
  output logic step_a_o,
  output logic step_b_o,
  output logic pre_o,
  output logic eval_o,
  output logic load_new_o,
  output logic load_pend_o,
  output logic pend_set_o
);
  ctl_state_e st_q, st_d;
  logic       pend_q;
  logic       idle;

  assign idle        = (st_q == ST_IDLE);
  assign step_a_o    = idle & wr_req_i;
  assign step_b_o    = (st_q == ST_WRB);
  assign pre_o       = (st_q == ST_PRE);
  assign eval_o      = (st_q == ST_EVAL);
  // a fresh request wins over a held one
  assign load_new_o  = (idle & ~wr_req_i & srch_req_i) | (step_b_o & srch_req_i);
  assign load_pend_o = step_b_o & ~srch_req_i & pend_q;
  assign pend_set_o  = step_a_o & srch_req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_req_i)        st_d = ST_WRB;
        else if (srch_req_i) st_d = ST_PRE;
      end
      ST_WRB:  st_d = (srch_req_i | pend_q) ? ST_PRE : ST_IDLE;
      ST_PRE:  st_d = ST_EVAL;
      ST_EVAL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (pend_set_o)    pend_q <= 1'b1;
      else if (step_b_o) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int WORDS = 8,
  parameter int BITS  = 8,
  parameter int AW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_en_i,
  input  logic [AW-1:0]     wa_addr_i,
  input  logic [2*BITS-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [AW-1:0]     wb_addr_i,
  input  logic [2*BITS-1:0] wb_data_i,
  input  logic [2*BITS-1:0] key_i,
  output logic [WORDS-1:0]  word_hit_o
);
  logic [BITS-1:0] one_q  [WORDS];
  logic [BITS-1:0] zero_q [WORDS];
  logic [BITS-1:0] wa_one, wb_zero, key_one, key_zero;

  always_comb begin
    for (int b = 0; b < BITS; b++) begin
      wa_one[b]   = wa_data_i[2*b+1];
      wb_zero[b]  = wb_data_i[2*b];
      key_one[b]  = key_i[2*b+1];
      key_zero[b] = key_i[2*b];
    end
  end

  // step A: one elements, step B: zero elements
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) begin
        one_q[w]  <= '0;
        zero_q[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (wa_en_i && (wa_addr_i == AW'(w))) one_q[w]  <= wa_one;
        if (wb_en_i && (wb_addr_i == AW'(w))) zero_q[w] <= wb_zero;
      end
    end
  end

  // a key zero meets a stored one element, or a key one meets a stored zero element
  for (genvar w = 0; w < WORDS; w++) begin : g_cmp
    assign word_hit_o[w] = ~|((key_zero & one_q[w]) | (key_one & zero_q[w]));
  end
endmodule

// File: rtl/tcam_matchline.sv
module tcam_matchline #(
  parameter int WORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             pre_i,
  input  logic             eval_i,
  input  logic [WORDS-1:0] word_hit_i,
  output logic [WORDS-1:0] ml_o,
  output logic [WORDS-1:0] ml_next_o
);
  logic [WORDS-1:0] ml_q;

  always_comb begin
    if (clear_i)     ml_next_o = '0;
    else if (pre_i)  ml_next_o = '1;
    else if (eval_i) ml_next_o = ml_q & word_hit_i;
    else             ml_next_o = ml_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ml_q <= '0;
    else         ml_q <= ml_next_o;
  end

  assign ml_o = ml_q;
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int WORDS = 8,
  parameter int AW    = 3
) (
  input  logic [WORDS-1:0] hits_i,
  output logic             any_o,
  output logic [AW-1:0]    idx_o,
  output logic             multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = AW'(i);
    end
  end

  assign any_o   = |hits_i;
  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_o = |(hits_i & (hits_i - WORDS'(1)));
endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int BITS  = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [2*BITS-1:0] wr_data_i,
  input  logic              srch_i,
  input  logic [2*BITS-1:0] srch_key_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [AW-1:0]     addr_o,
  output logic              multi_o
);
  logic step_a, step_b, pre_en, eval_en;
  logic load_new, load_pend, pend_set;

  logic [AW-1:0]     wr_addr_q;
  logic [2*BITS-1:0] wr_data_q;
  logic [2*BITS-1:0] key_q, pend_key_q;

  logic [WORDS-1:0] word_hit, ml_q, ml_next;
  logic             enc_any, enc_multi;
  logic [AW-1:0]    enc_idx;

  tcam_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_i),
    .srch_req_i  (srch_i),
    .step_a_o    (step_a),
    .step_b_o    (step_b),
    .pre_o       (pre_en),
    .eval_o      (eval_en),
    .load_new_o  (load_new),
    .load_pend_o (load_pend),
    .pend_set_o  (pend_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      key_q      <= '0;
      pend_key_q <= '0;
    end else begin
      if (step_a) begin
        wr_addr_q <= wr_addr_i;
        wr_data_q <= wr_data_i;
      end
      if (pend_set)       pend_key_q <= srch_key_i;
      if (load_new)       key_q      <= srch_key_i;
      else if (load_pend) key_q      <= pend_key_q;
    end
  end

  tcam_store #(.WORDS(WORDS), .BITS(BITS), .AW(AW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wa_en_i    (step_a),
    .wa_addr_i  (wr_addr_i),
    .wa_data_i  (wr_data_i),
    .wb_en_i    (step_b),
    .wb_addr_i  (wr_addr_q),
    .wb_data_i  (wr_data_q),
    .key_i      (key_q),
    .word_hit_o (word_hit)
  );

  tcam_matchline #(.WORDS(WORDS)) u_ml (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (step_a | step_b),
    .pre_i      (pre_en),
    .eval_i     (eval_en),
    .word_hit_i (word_hit),
    .ml_o       (ml_q),
    .ml_next_o  (ml_next)
  );

  tcam_prio_enc #(.WORDS(WORDS), .AW(AW)) u_enc (
    .hits_i  (ml_next),
    .any_o   (enc_any),
    .idx_o   (enc_idx),
    .multi_o (enc_multi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hit_o   <= 1'b0;
      addr_o  <= '0;
      multi_o <= 1'b0;
    end else begin
      valid_o <= eval_en;
      if (eval_en) begin
        hit_o   <= enc_any;
        addr_o  <= enc_idx;
        multi_o <= enc_multi;
      end
    end
  end
endmodule

// File: rtl/tcam_array_chk.sv
module tcam_array_chk #(
  parameter int WORDS = 8,
  parameter int BITS  = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_b_i,
  input logic             pre_i,
  input logic             eval_i,
  input logic [WORDS-1:0] ml_i,
  input logic             valid_i,
  input logic             hit_i,
  input logic [AW-1:0]    addr_i,
  input logic             multi_i
);
  logic [WORDS-1:0] below;
  always_comb below = (WORDS'(1) << addr_i) - WORDS'(1);

  p_flags_low_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_b_i |-> (ml_i == '0));
  p_flags_high_eval_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> (&ml_i));
  p_pre_then_eval_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> eval_i);
  p_eval_then_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> valid_i);
  p_valid_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(eval_i));
  p_hit_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (hit_i == (|ml_i)));
  p_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_i) |-> (ml_i[addr_i] && ((ml_i & below) == '0)));
  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hit_i) |-> (addr_i == '0 && !multi_i));
  p_multi_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (multi_i == ($countones(ml_i) > 1)));
endmodule

bind tcam_array tcam_array_chk #(.WORDS(WORDS), .BITS(BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .step_b_i (step_b),
  .pre_i    (pre_en),
  .eval_i   (eval_en),
  .ml_i     (ml_q),
  .valid_i  (valid_o),
  .hit_i    (hit_o),
  .addr_i   (addr_o),
  .multi_i  (multi_o)
);

// File: tb/sim_tcam_array.sv
`timescale 1ns/1ps
module sim_tcam_array;
  localparam int WORDS = 8;
  localparam int BITS  = 8;
  localparam int AW    = 3;
  localparam logic [1:0] DC = 2'b00, ZR = 2'b01, ON = 2'b10, RS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, srch = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [2*BITS-1:0] wr_data = '0, key = '0;
  logic valid, hit, multi;
  logic [AW-1:0] addr;

  always #2 clk = ~clk;

  tcam_array #(.WORDS(WORDS), .BITS(BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .srch_i(srch), .srch_key_i(key), .valid_o(valid), .hit_o(hit), .addr_o(addr),
    .multi_o(multi)
  );

  typedef struct {
    logic          hit;
    logic [AW-1:0] addr;
    logic          multi;
    int            due;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cnt = 0, pushed = 0, popped = 0;
  bit finished = 0;
  logic [1:0] mdl [WORDS][BITS];
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [2*BITS-1:0] pat4(input logic [1:0] a, b, c, d);
    logic [2*BITS-1:0] r;
    r = '0;
    r[1:0] = a; r[3:2] = b; r[5:4] = c; r[7:6] = d;
    return r;
  endfunction

  function automatic logic [2*BITS-1:0] all_rsv();
    return {BITS{RS}};
  endfunction

  // R1/R2/R3/R4 reference model
  function automatic exp_t predict(input logic [2*BITS-1:0] k, input int due, input string tag);
    exp_t e;
    int n = 0;
    e.hit = 1'b0; e.addr = '0; e.multi = 1'b0; e.due = due; e.tag = tag;
    for (int w = 0; w < WORDS; w++) begin
      bit ok = 1;
      for (int b = 0; b < BITS; b++) begin
        logic [1:0] kc, sc;
        kc = k[2*b +: 2];
        sc = mdl[w][b];
        if (!(kc == DC || sc == DC || (kc == sc && kc != RS))) ok = 0;
      end
      if (ok) begin
        if (n == 0) e.addr = AW'(w);
        n++;
      end
    end
    e.hit = (n > 0);
    e.multi = (n > 1);
    return e;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [2*BITS-1:0] d);
    for (int b = 0; b < BITS; b++) mdl[a][b] = d[2*b +: 2];
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid && !finished) begin
      if (q.size() == 0) begin
        check(0, "R10 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        popped++;
        check(cnt == e.due, {e.tag, " R5 timing"}, cnt, e.due);
        check(hit == e.hit, {e.tag, " R2 hit"}, hit, e.hit);
        check(addr == e.addr, {e.tag, " R3 addr"}, addr, e.addr);
        check(multi == e.multi, {e.tag, " R4 multi"}, multi, e.multi);
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [2*BITS-1:0] d);
    wr = 1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr = 0;
    @(negedge clk);
  endtask

  task automatic do_search(input logic [2*BITS-1:0] k, input string tag);
    srch = 1; key = k;
    q.push_back(predict(k, cnt + 3, tag)); pushed++;
    @(negedge clk);
    srch = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] rnd2();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[17:16];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(valid == 0, "R11 valid", valid, 0);
    check(hit == 0, "R11 hit", hit, 0);
    check(addr == 0, "R11 addr", addr, 0);
    check(multi == 0, "R11 multi", multi, 0);
    rst_n = 1;
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < BITS; b++) mdl[w][b] = DC;
    @(negedge clk);
    // R11: every entry is don't-care after reset
    do_search(pat4(ON, ZR, ON, ZR), "R11 wildcard after reset");

    // R7 program: entries 2..7 reserved, 0 and 1 as the vectors below
    for (int w = 2; w < WORDS; w++) do_write(AW'(w), all_rsv());
    do_write(0, pat4(ZR, ZR, ZR, ZR));
    do_write(0, pat4(ON, DC, ON, ZR));     // overwrite of old content, R7
    do_write(1, pat4(ON, ON, ON, ON));
    do_write(1, pat4(ZR, DC, ZR, ON));

    do_search(pat4(ON, ON, DC, ZR), "R1 vector a");
    do_search(pat4(ZR, ON, DC, ON), "R1 vector b");
    do_search(pat4(ON, DC, ZR, DC), "R2 no match");
    do_search({BITS{DC}}, "R1 reserved vs wildcard key");
    do_search(pat4(DC, ZR, DC, DC), "R4 two hits");
    do_write(0, all_rsv());
    do_search(pat4(ZR, DC, ZR, DC), "R7 rewritten entry");

    // R8 search together with write: sees new content
    srch = 1; key = pat4(ON, ON, DC, ZR);
    wr = 1; wr_addr = 5; wr_data = pat4(ON, DC, ON, ZR);
    model_write(5, pat4(ON, DC, ON, ZR));
    q.push_back(predict(pat4(ON, ON, DC, ZR), cnt + 4, "R8 stalled with write")); pushed++;
    @(negedge clk); srch = 0; wr = 0;
    repeat (3) @(negedge clk);

    // R8 search in second write cycle
    wr = 1; wr_addr = 4; wr_data = pat4(ZR, ZR, ZR, ZR);
    model_write(4, pat4(ZR, ZR, ZR, ZR));
    @(negedge clk); wr = 0;
    srch = 1; key = pat4(ZR, DC, DC, DC);
    q.push_back(predict(pat4(ZR, DC, DC, DC), cnt + 3, "R8 stalled in step b")); pushed++;
    @(negedge clk); srch = 0;
    repeat (2) @(negedge clk);

    // R9 write during precharge is dropped
    srch = 1; key = pat4(ON, DC, DC, DC);
    q.push_back(predict(pat4(ON, DC, DC, DC), cnt + 3, "R9 search before drop")); pushed++;
    @(negedge clk); srch = 0;
    wr = 1; wr_addr = 1; wr_data = all_rsv();
    @(negedge clk); wr = 0;
    @(negedge clk);
    do_search(pat4(ZR, DC, ZR, DC), "R9 entry kept after busy write");

    // R9 write during second write cycle is dropped
    wr = 1; wr_addr = 2; wr_data = pat4(ZR, ZR, ZR, ZR);
    model_write(2, pat4(ZR, ZR, ZR, ZR));
    @(negedge clk);
    wr_addr = 3; wr_data = {BITS{DC}};
    @(negedge clk); wr = 0;
    do_search(pat4(ON, DC, DC, DC), "R9 entry kept after overlapped write");

    // R10 second search during precharge produces nothing
    srch = 1; key = pat4(ZR, DC, ZR, DC);
    q.push_back(predict(pat4(ZR, DC, ZR, DC), cnt + 3, "R10 first search")); pushed++;
    @(negedge clk); key = {BITS{DC}};
    @(negedge clk); srch = 0;
    repeat (2) @(negedge clk);

    // mixed patterns
    for (int it = 0; it < 40; it++) begin
      logic [2*BITS-1:0] d, k;
      logic [AW-1:0] a;
      for (int b = 0; b < BITS; b++) d[2*b +: 2] = rnd2();
      a = AW'(rnd2()) ^ AW'(it);
      do_write(a, d);
      a = AW'(it * 3);
      for (int b = 0; b < BITS; b++) begin
        k[2*b +: 2] = rnd2()[0] ? DC : mdl[a][b];
        if (k[2*b +: 2] == RS) k[2*b +: 2] = DC;
      end
      if (it % 5 == 4) k[1:0] = rnd2();
      do_search(k, "R2 mixed");
    end

    repeat (6) @(negedge clk);
    check(q.size() == 0, "R10 results pending", q.size(), 0);
    check(popped == pushed, "R10 result count", popped, pushed);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cnt, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule